// File: doc/BRIEF.md
# Converter Power and Conversion Sequencer

This block controls one converter. It decides when the conversion core runs and which analog support circuits stay powered. When a conversion-start pulse arrives from the serial front end, it runs a conversion. The conversion is modelled as a fixed number of steps. Each step lasts a programmable number of system clocks, which stand in for the slower conversion clock. When the conversion ends, the block reads a two-bit power field held by the serial front end. That field chooses whether the block stays fully powered, drops into standby (reference buffer and bandgap kept on) or drops into full power-down (only the bandgap kept on).

A wake pulse brings the block back. The serial front end raises that pulse one bit after it has received a valid write address. From standby the block returns to idle at once. From full power-down it first runs a programmable settle window. An active-low shutdown pin overrides everything: it cuts power and aborts any running conversion in the next cycle. The result-valid flag survives every power-down mode, so the last result stays readable.

States: `S_IDLE` (powered, waiting), `S_CONV` (converting), `S_STBY` (standby), `S_FULL` (software full power-down), `S_HWOFF` (pin shutdown), `S_SETTLE` (reference recovery). Transitions: IDLE→CONV on start; CONV→IDLE/STBY/FULL on done according to the power field; STBY→IDLE on wake; FULL→SETTLE on wake; HWOFF→SETTLE on pin release; SETTLE→IDLE when the window expires; any state→HWOFF while the pin is low.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is held and right after it, the state is idle: `core_en`, `ref_buf_en` and `bandgap_en` are 1, and `busy`, `conv_done` and `result_valid` are 0.
- R2: A `conv_start` pulse seen in idle raises `busy` from the next cycle. `busy` then stays high for exactly CONV_STEPS*TICK_DIV cycles, and `conv_done` is a one-cycle pulse in the last of those cycles.
- R3: `result_valid` becomes 1 in the cycle after a completed conversion. After that, only reset clears it, so it stays 1 through standby, full power-down and pin shutdown.
- R4: `pd_mode` is read only in the `conv_done` cycle, so changing it mid-conversion does not shorten the conversion. The values mean: bit1=0 (00 or 01), stay powered in idle; 10, standby (`core_en`=0, `ref_buf_en`=1); 11, full power-down (`core_en`=0, `ref_buf_en`=0). `bandgap_en` is 1 in every state.
- R5: A `wake` pulse in standby returns the block to idle in the next cycle, with no settle window.
- R6: A `wake` pulse in software full power-down starts a settle window of exactly SETTLE_CYC cycles. During the window `ref_buf_en`=1 and `core_en`=0. After it the block is idle.
- R7: `shdn_n`=0 forces full power-down from the next cycle, with `busy`, `core_en` and `ref_buf_en` at 0. It aborts a running conversion without a `conv_done` pulse or a result, even in the cycle the conversion would have finished. `wake` has no effect while the pin is low. Releasing the pin starts the SETTLE_CYC settle window.
- R8: `conv_start` is ignored outside idle, and `wake` is ignored in idle, during a conversion and during settle.
- R9: With `pd_mode`=10 on every conversion, the block shuts itself down after each result. A start issued in the cycle after the wake is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_mode | input | 2 | Power field held by the serial front end |
| conv_start | input | 1 | One-cycle request to start a conversion |
| wake | input | 1 | One-cycle wake event after a valid write address |
| shdn_n | input | 1 | Active-low hardware shutdown pin |
| core_en | output | 1 | Conversion core enable |
| ref_buf_en | output | 1 | Reference buffer enable |
| bandgap_en | output | 1 | Bandgap enable |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse when a conversion completes |
| result_valid | output | 1 | A completed result is held |

## Verification
The overlap that matters is the shutdown pin falling in the exact cycle the last conversion step would complete. The bench drives `shdn_n` low in the cycle where its own conversion counter sits at the final count. It then expects no `conv_done` pulse, no change to `result_valid` and a move to shutdown rather than to the mode chosen by `pd_mode`. A second overlap puts a `wake` and a `conv_start` in a state where only one of them is legal. The reference model decides which one wins, and each output is compared against the model on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CONV   = 3'd1,
        S_STBY   = 3'd2,
        S_FULL   = 3'd3,
        S_HWOFF  = 3'd4,
        S_SETTLE = 3'd5
    } seq_state_t;

    localparam logic [1:0] PD_STBY = 2'b10;
    localparam logic [1:0] PD_FULL = 2'b11;
endpackage

// File: rtl/pwr_seq_tick.sv
module pwr_seq_tick #(
    parameter int TICK_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == DW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_conv.sv
module pwr_seq_conv #(
    parameter int CONV_STEPS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int SW = $clog2(CONV_STEPS + 1);

    logic [SW-1:0] step_q;

    assign done = run && tick && (step_q == SW'(CONV_STEPS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            step_q <= '0;
        end else if (run && tick) begin
            step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_settle.sv
module pwr_seq_settle #(
    parameter int SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] left_q;

    assign expired = run && (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(SETTLE_CYC - 1);
        end else if (run && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int CONV_STEPS = 12,
    parameter int TICK_DIV   = 80,
    parameter int SETTLE_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pd_mode,
    input  logic       conv_start,
    input  logic       wake,
    input  logic       shdn_n,
    output logic       core_en,
    output logic       ref_buf_en,
    output logic       bandgap_en,
    output logic       busy,
    output logic       conv_done,
    output logic       result_valid
);
    seq_state_t state_q, state_d;
    logic       start_ok;
    logic       conv_run;
    logic       tick;
    logic       done_raw;
    logic       settle_load;
    logic       settle_run;
    logic       settle_exp;
    logic       valid_q;

    assign conv_run    = (state_q == S_CONV);
    assign settle_run  = (state_q == S_SETTLE);
    assign start_ok    = (state_q == S_IDLE) && shdn_n && conv_start;
    assign settle_load = (state_d == S_SETTLE) && (state_q != S_SETTLE);

    pwr_seq_tick #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .run(conv_run), .tick(tick)
    );

    pwr_seq_conv #(.CONV_STEPS(CONV_STEPS)) conv_i (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .run(conv_run),
        .tick(tick), .done(done_raw)
    );

    pwr_seq_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk(clk), .rst_n(rst_n), .load(settle_load), .run(settle_run),
        .expired(settle_exp)
    );

    // next-state logic: the pin overrides every state
    always_comb begin
        state_d = state_q;
        if (!shdn_n) begin
            state_d = S_HWOFF;
        end else begin
            unique case (state_q)
                S_IDLE:   if (conv_start) state_d = S_CONV;
                S_CONV: begin
                    if (done_raw) begin
                        if (pd_mode == PD_STBY)      state_d = S_STBY;
                        else if (pd_mode == PD_FULL) state_d = S_FULL;
                        else                         state_d = S_IDLE;
                    end
                end
                S_STBY:   if (wake) state_d = S_IDLE;
                S_FULL:   if (wake) state_d = S_SETTLE;
                S_HWOFF:  state_d = S_SETTLE;
                S_SETTLE: if (settle_exp) state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (done_raw && shdn_n) valid_q <= 1'b1;
        end
    end

    // output decode from state
    always_comb begin
        core_en    = 1'b0;
        ref_buf_en = 1'b0;
        bandgap_en = 1'b1;
        busy       = 1'b0;
        unique case (state_q)
            S_IDLE:   begin core_en = 1'b1; ref_buf_en = 1'b1; end
            S_CONV:   begin core_en = 1'b1; ref_buf_en = 1'b1; busy = 1'b1; end
            S_STBY:   ref_buf_en = 1'b1;
            S_SETTLE: ref_buf_en = 1'b1;
            S_FULL:   ref_buf_en = 1'b0;
            S_HWOFF:  ref_buf_en = 1'b0;
            default:  ref_buf_en = 1'b0;
        endcase
    end

    assign conv_done    = done_raw && shdn_n;
    assign result_valid = valid_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pd_mode,
    input logic       conv_start,
    input logic       wake,
    input logic       shdn_n,
    input logic       core_en,
    input logic       ref_buf_en,
    input logic       bandgap_en,
    input logic       busy,
    input logic       conv_done,
    input logic       result_valid
);
    AST_PIN_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!busy && !core_en && !ref_buf_en)); // R7
    AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> busy); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_start)); // R2
    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> result_valid); // R3
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> result_valid); // R3
    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && pd_mode == 2'b10) |=> (!core_en && ref_buf_en && bandgap_en)); // R4
    AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && pd_mode == 2'b11) |=> (!core_en && !ref_buf_en && bandgap_en)); // R4
    AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done && shdn_n) |=> busy); // R4
    AST_IDLE_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_en && shdn_n) |=> !busy); // R8
endmodule

bind pwr_seq_top pwr_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pd_mode(pd_mode), .conv_start(conv_start),
    .wake(wake), .shdn_n(shdn_n), .core_en(core_en), .ref_buf_en(ref_buf_en),
    .bandgap_en(bandgap_en), .busy(busy), .conv_done(conv_done),
    .result_valid(result_valid)
);

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
    localparam int STEPS  = 12;
    localparam int DIV    = 80;
    localparam int SETTLE = 200;
    localparam int CONVN  = STEPS * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pd_mode = 2'b00;
    logic       conv_start = 1'b0;
    logic       wake = 1'b0;
    logic       shdn_n = 1'b1;
    logic       core_en, ref_buf_en, bandgap_en, busy, conv_done, result_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model: 0 idle, 1 conv, 2 stby, 3 full, 4 pin-off, 5 settle
    int mst = 0;
    int ccnt = 0;
    int scnt = 0;
    bit mvalid = 1'b0;

    always #4 clk = ~clk;

    pwr_seq_top #(.CONV_STEPS(STEPS), .TICK_DIV(DIV), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .pd_mode(pd_mode), .conv_start(conv_start),
        .wake(wake), .shdn_n(shdn_n), .core_en(core_en), .ref_buf_en(ref_buf_en),
        .bandgap_en(bandgap_en), .busy(busy), .conv_done(conv_done),
        .result_valid(result_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; ccnt = 0; scnt = 0; mvalid = 1'b0;
        end else if (!shdn_n) begin
            mst = 4;
        end else begin
            case (mst)
                0: if (conv_start) begin mst = 1; ccnt = 0; end
                1: begin
                    if (ccnt == CONVN - 1) begin
                        mvalid = 1'b1;
                        mst = (pd_mode == 2'b10) ? 2 : (pd_mode == 2'b11) ? 3 : 0;
                    end else ccnt++;
                end
                2: if (wake) mst = 0;
                3: if (wake) begin mst = 5; scnt = 0; end
                4: begin mst = 5; scnt = 0; end
                5: begin scnt++; if (scnt == SETTLE) mst = 0; end
                default: mst = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk((mst == 4) ? "R7 core_en" : "R4 core_en", core_en, (mst <= 1));
            chk((mst == 4) ? "R7 ref_buf_en" : "R4 ref_buf_en", ref_buf_en,
                (mst <= 2 || mst == 5));
            chk("R4 bandgap_en", bandgap_en, 1);
            chk("R2 busy", busy, (mst == 1));
            chk("R2 conv_done", conv_done, (mst == 1 && ccnt == CONVN - 1 && shdn_n));
            chk("R3 result_valid", result_valid, mvalid);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        conv_start = 1'b1; step(1); conv_start = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; step(1); wake = 1'b0;
    endtask

    task automatic wait_not_conv();
        while (mst == 1) step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 core_en", core_en, 1);
        chk("R1 ref_buf_en", ref_buf_en, 1);
        chk("R1 busy", busy, 0);
        chk("R1 result_valid", result_valid, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 idle busy", busy, 0);

        // normal conversion, stray start and wake mid-conversion (R2, R8)
        pd_mode = 2'b00;
        pulse_start();
        step(1);
        chk("R2 busy after start", busy, 1);
        step(20);
        pulse_start();
        pulse_wake();
        chk("R8 busy continues", busy, 1);
        wait_not_conv();
        chk("R3 valid after done", result_valid, 1);

        // 01 stays powered (R4)
        pd_mode = 2'b01;
        pulse_start();
        wait_not_conv();
        chk("R4 pd01 core_en", core_en, 1);
        pulse_wake();
        chk("R8 wake in idle", core_en, 1);

        // standby, ignored start, wake, immediate restart (R5, R8, R9)
        pd_mode = 2'b10;
        pulse_start();
        wait_not_conv();
        chk("R4 stby core_en", core_en, 0);
        chk("R4 stby ref_buf_en", ref_buf_en, 1);
        pulse_start();
        chk("R8 start in stby", busy, 0);
        pulse_wake();
        chk("R5 wake stby core_en", core_en, 1);
        pulse_start();
        chk("R9 immediate start", busy, 1);
        wait_not_conv();
        chk("R9 auto shutdown", core_en, 0);
        pulse_wake();

        // pd change during conversion, full power-down, settle (R4, R6)
        pd_mode = 2'b00;
        pulse_start();
        step(100);
        pd_mode = 2'b11;
        wait_not_conv();
        chk("R4 full ref_buf_en", ref_buf_en, 0);
        pulse_start();
        chk("R8 start in full", busy, 0);
        pulse_wake();
        begin
            int cyc = 1;
            while (!core_en && cyc < SETTLE + 10) begin step(1); cyc++; end
            chk("R6 settle length", cyc, SETTLE + 1);
        end
        pulse_start();
        wait_not_conv();

        // pin shutdown mid-conversion, wake ignored while low (R7)
        pd_mode = 2'b00;
        pulse_start();
        step(50);
        shdn_n = 1'b0;
        step(1);
        chk("R7 busy aborted", busy, 0);
        pulse_wake();
        step(3);
        chk("R7 wake ignored", core_en, 0);
        shdn_n = 1'b1;
        step(1);
        chk("R7 settle ref_buf_en", ref_buf_en, 1);
        step(SETTLE + 2);
        chk("R7 idle after settle", core_en, 1);

        // pin falls in the done cycle (R7)
        pulse_start();
        while (!(mst == 1 && ccnt == CONVN - 1)) step(1);
        shdn_n = 1'b0;
        @(negedge clk);
        chk("R7 no done in abort cycle", conv_done, 0);
        step(2);
        chk("R7 shutdown wins", ref_buf_en, 0);
        shdn_n = 1'b1;
        step(SETTLE + 3);
        chk("R3 valid kept", result_valid, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule